// File: doc/BRIEF.md
# Matrix Rotate and Transpose Grid

This block is a square grid of N×N storage elements. Each element holds one data word and nothing more. A small input FIFO feeds the grid one word at a time, in row-major order, and a small output FIFO takes words back out in the same order. While the grid holds a matrix, one command turns the whole matrix a quarter turn clockwise, or mirrors it across its main diagonal. Every element takes its new value on the same clock edge. The value arrives over fixed element-to-element wiring, and nothing else is stored on the way.

A controller sequences the grid through five states: idle, loading, ready, executing and draining. After reset the grid loads N×N words from the input FIFO. It then waits in the ready state, where it accepts rotate, transpose or drain commands. Any number of rotate and transpose commands can be applied, one after another, before the drain. After the drain the grid goes back to loading the next matrix. Commands that arrive while the controller is not ready are discarded.

Top module: `mat_rot_array`

## Requirements
- R1: After N×N words have been accepted on the input port, the grid holds them in row-major order (word k goes to row k/N, column k%N), and `loaded_o` then goes high. `loaded_o` stays low while fewer than N×N words have been accepted.
- R2: In the ready state, a command with `cmd_op_i` = 2'b01 sets every element at once so that new[i][j] = old[N-1-j][i], which is a clockwise quarter turn. `busy_o` is high for exactly one cycle, and then `loaded_o` returns.
- R3: In the ready state, a command with `cmd_op_i` = 2'b10 sets every element at once so that new[i][j] = old[j][i]. Elements on the diagonal keep their values.
- R4: Commands can be chained. Four rotates give back the original matrix, two transposes give back the original matrix, and a rotate followed by a transpose gives the composition of the two.
- R5: A command that arrives while `busy_o` is high is discarded. This covers commands during loading and in the cycle in which an operation executes. A command with `cmd_op_i` = 2'b00 has no effect, even in the ready state.
- R6: In the ready state, a command with `cmd_op_i` = 2'b11 moves the N×N words to the output port in row-major order, each exactly once. The controller then returns to loading.
- R7: While `out_valid_o` is high and `out_ready_i` is low, `out_data_o` holds its value. Draining waits while the output FIFO is full and then continues, with no word lost or repeated.
- R8: While `rst_ni` is low and just after it is released, `out_valid_o` and `loaded_o` are low, while `busy_o` and `in_ready_o` are high. Reset clears both FIFO pointers and every element.
- R9: `in_ready_o` goes low once FIFO_DEPTH words are waiting in the input FIFO and the grid is not loading. Words accepted early in this way become the first words of the next matrix.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| in_valid_i | input | 1 | Input word is valid |
| in_data_i | input | W | Input word |
| in_ready_o | output | 1 | Input FIFO has room |
| out_valid_o | output | 1 | Output word is valid |
| out_data_o | output | W | Output word |
| out_ready_i | input | 1 | Consumer takes the output word |
| cmd_valid_i | input | 1 | Command strobe |
| cmd_op_i | input | 2 | 00 none, 01 rotate, 10 transpose, 11 drain |
| busy_o | output | 1 | Controller is not in the ready state |
| loaded_o | output | 1 | Grid holds a matrix and accepts commands |

## Verification
Two situations are hard to reach from the ports.

The first is a command that lands exactly in the executing cycle. The bench gets there by holding the rotate strobe for two consecutive edges. Only one quarter turn may then appear in the drained matrix.

The second is a drain that stalls because the output FIFO is full. The bench holds `out_ready_i` low well past the FIFO depth and checks that the head word stays stable. It then releases the consumer and checks that every word of the matrix arrives exactly once.

Input backpressure is reached by pushing the next matrix's leading words while the grid is still ready. That fills the input FIFO, which should drop `in_ready_o`.

// File: rtl/mat_rot_pkg.sv
package mat_rot_pkg;
  typedef enum logic [1:0] {
    CMD_NOP   = 2'b00,
    CMD_ROT   = 2'b01,
    CMD_TRN   = 2'b10,
    CMD_DRAIN = 2'b11
  } cmd_e;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_LOAD,
    ST_READY,
    ST_EXEC,
    ST_DRAIN
  } state_e;
endpackage

// File: rtl/mat_fifo.sv
module mat_fifo #(
  parameter int W     = 8,
  parameter int DEPTH = 4
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic         push_i,
  input  logic [W-1:0] wdata_i,
  input  logic         pop_i,
  output logic [W-1:0] rdata_o,
  output logic         full_o,
  output logic         empty_o
);
  localparam int AW = (DEPTH > 1) ? $clog2(DEPTH) : 1;

  logic [W-1:0] mem_q [DEPTH];
  logic [AW:0]  wr_ptr_q, rd_ptr_q;
  logic         do_push, do_pop;

  assign empty_o = (wr_ptr_q == rd_ptr_q);
  assign full_o  = (wr_ptr_q[AW-1:0] == rd_ptr_q[AW-1:0]) && (wr_ptr_q[AW] != rd_ptr_q[AW]);
  assign do_push = push_i && !full_o;
  assign do_pop  = pop_i && !empty_o;
  assign rdata_o = mem_q[rd_ptr_q[AW-1:0]];

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      wr_ptr_q <= '0;
      rd_ptr_q <= '0;
    end else begin
      if (do_push) wr_ptr_q <= wr_ptr_q + 1'b1;
      if (do_pop)  rd_ptr_q <= rd_ptr_q + 1'b1;
    end
  end

  always_ff @(posedge clk_i) begin
    if (do_push) mem_q[wr_ptr_q[AW-1:0]] <= wdata_i;
  end
endmodule

// File: rtl/mat_pe.sv
module mat_pe #(
  parameter int W = 8
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic         load_en_i,
  input  logic [W-1:0] load_data_i,
  input  logic         exec_en_i,
  input  logic         exec_trn_i,
  input  logic [W-1:0] rot_src_i,
  input  logic [W-1:0] trn_src_i,
  output logic [W-1:0] q_o
);
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)        q_o <= '0;
    else if (load_en_i) q_o <= load_data_i;
    else if (exec_en_i) q_o <= exec_trn_i ? trn_src_i : rot_src_i;
  end
endmodule

// File: rtl/mat_pe_grid.sv
module mat_pe_grid #(
  parameter int N     = 4,
  parameter int W     = 8,
  parameter int IDX_W = $clog2(N*N)
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             load_en_i,
  input  logic [IDX_W-1:0] load_idx_i,
  input  logic [W-1:0]     load_data_i,
  input  logic             exec_en_i,
  input  logic             exec_trn_i,
  output logic [W-1:0]     cell_o [N*N]
);
  for (genvar r = 0; r < N; r++) begin : g_row
    for (genvar c = 0; c < N; c++) begin : g_col
      localparam int SELF = r*N + c;
      // clockwise quarter turn reads row N-1-c, column r; transpose reads row c, column r
      localparam int ROT  = (N-1-c)*N + r;
      localparam int TRN  = c*N + r;
      logic hit;
      assign hit = load_en_i && (load_idx_i == IDX_W'(SELF));
      mat_pe #(.W(W)) u_pe (
        .clk_i      (clk_i),
        .rst_ni     (rst_ni),
        .load_en_i  (hit),
        .load_data_i(load_data_i),
        .exec_en_i  (exec_en_i),
        .exec_trn_i (exec_trn_i),
        .rot_src_i  (cell_o[ROT]),
        .trn_src_i  (cell_o[TRN]),
        .q_o        (cell_o[SELF])
      );
    end
  end
endmodule

// File: rtl/mat_ctrl.sv
module mat_ctrl
  import mat_rot_pkg::*;
#(
  parameter int N     = 4,
  parameter int IDX_W = $clog2(N*N)
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             in_empty_i,
  input  logic             out_full_i,
  input  logic             cmd_valid_i,
  input  cmd_e             cmd_op_i,
  output logic             in_pop_o,
  output logic             load_en_o,
  output logic [IDX_W-1:0] idx_o,
  output logic             exec_en_o,
  output logic             exec_trn_o,
  output logic             out_push_o,
  output logic             busy_o,
  output logic             loaded_o
);
  localparam logic [IDX_W-1:0] LAST = IDX_W'(N*N-1);

  state_e           state_q, state_d;
  logic [IDX_W-1:0] cnt_q, cnt_d;
  logic             trn_q, trn_d;

  always_comb begin
    state_d    = state_q;
    cnt_d      = cnt_q;
    trn_d      = trn_q;
    in_pop_o   = 1'b0;
    load_en_o  = 1'b0;
    exec_en_o  = 1'b0;
    out_push_o = 1'b0;
    case (state_q)
      ST_IDLE: state_d = ST_LOAD;
      ST_LOAD: begin
        if (!in_empty_i) begin
          in_pop_o  = 1'b1;
          load_en_o = 1'b1;
          if (cnt_q == LAST) begin
            cnt_d   = '0;
            state_d = ST_READY;
          end else begin
            cnt_d = cnt_q + 1'b1;
          end
        end
      end
      ST_READY: begin
        if (cmd_valid_i) begin
          case (cmd_op_i)
            CMD_ROT:   begin trn_d = 1'b0; state_d = ST_EXEC; end
            CMD_TRN:   begin trn_d = 1'b1; state_d = ST_EXEC; end
            CMD_DRAIN: state_d = ST_DRAIN;
            default:   ;
          endcase
        end
      end
      ST_EXEC: begin
        exec_en_o = 1'b1;
        state_d   = ST_READY;
      end
      ST_DRAIN: begin
        if (!out_full_i) begin
          out_push_o = 1'b1;
          if (cnt_q == LAST) begin
            cnt_d   = '0;
            state_d = ST_IDLE;
          end else begin
            cnt_d = cnt_q + 1'b1;
          end
        end
      end
      default: state_d = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q <= ST_IDLE;
      cnt_q   <= '0;
      trn_q   <= 1'b0;
    end else begin
      state_q <= state_d;
      cnt_q   <= cnt_d;
      trn_q   <= trn_d;
    end
  end

  assign idx_o      = cnt_q;
  assign exec_trn_o = trn_q;
  assign busy_o     = (state_q != ST_READY);
  assign loaded_o   = (state_q == ST_READY);
endmodule

// File: rtl/mat_rot_array.sv
module mat_rot_array
  import mat_rot_pkg::*;
#(
  parameter int N          = 4,
  parameter int W          = 8,
  parameter int FIFO_DEPTH = 4
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic         in_valid_i,
  input  logic [W-1:0] in_data_i,
  output logic         in_ready_o,
  output logic         out_valid_o,
  output logic [W-1:0] out_data_o,
  input  logic         out_ready_i,
  input  logic         cmd_valid_i,
  input  logic [1:0]   cmd_op_i,
  output logic         busy_o,
  output logic         loaded_o
);
  localparam int IDX_W = $clog2(N*N);

  logic             in_full, in_empty, in_pop;
  logic [W-1:0]     in_head;
  logic             out_full, out_empty, out_push;
  logic             load_en, exec_en, exec_trn;
  logic [IDX_W-1:0] idx;
  logic [W-1:0]     cell_q [N*N];

  mat_fifo #(.W(W), .DEPTH(FIFO_DEPTH)) u_in_fifo (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .push_i (in_valid_i),
    .wdata_i(in_data_i),
    .pop_i  (in_pop),
    .rdata_o(in_head),
    .full_o (in_full),
    .empty_o(in_empty)
  );

  mat_ctrl #(.N(N), .IDX_W(IDX_W)) u_ctrl (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .in_empty_i (in_empty),
    .out_full_i (out_full),
    .cmd_valid_i(cmd_valid_i),
    .cmd_op_i   (cmd_e'(cmd_op_i)),
    .in_pop_o   (in_pop),
    .load_en_o  (load_en),
    .idx_o      (idx),
    .exec_en_o  (exec_en),
    .exec_trn_o (exec_trn),
    .out_push_o (out_push),
    .busy_o     (busy_o),
    .loaded_o   (loaded_o)
  );

  mat_pe_grid #(.N(N), .W(W), .IDX_W(IDX_W)) u_grid (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .load_en_i  (load_en),
    .load_idx_i (idx),
    .load_data_i(in_head),
    .exec_en_i  (exec_en),
    .exec_trn_i (exec_trn),
    .cell_o     (cell_q)
  );

  mat_fifo #(.W(W), .DEPTH(FIFO_DEPTH)) u_out_fifo (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .push_i (out_push),
    .wdata_i(cell_q[idx]),
    .pop_i  (out_ready_i),
    .rdata_o(out_data_o),
    .full_o (out_full),
    .empty_o(out_empty)
  );

  assign in_ready_o  = !in_full;
  assign out_valid_o = !out_empty;
endmodule

// File: rtl/mat_rot_array_chk.sv
module mat_rot_array_chk
  import mat_rot_pkg::*;
#(
  parameter int N = 4,
  parameter int W = 8
) (
  input logic         clk_i,
  input logic         rst_ni,
  input logic         out_valid_o,
  input logic         out_ready_i,
  input logic [W-1:0] out_data_o,
  input logic         cmd_valid_i,
  input logic [1:0]   cmd_op_i,
  input logic         loaded_o,
  input logic         busy_o,
  input logic         exec_en,
  input logic         exec_trn,
  input logic         out_push,
  input logic         out_full,
  input logic [W-1:0] cell_q [N*N]
);
  p_out_hold_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    out_valid_o && !out_ready_i |=> out_valid_o && $stable(out_data_o));

  p_no_push_full_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    out_push |-> !out_full);

  p_rot_one_cycle_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    loaded_o && cmd_valid_i && (cmd_op_i == CMD_ROT) |=> busy_o ##1 loaded_o);

  p_exec_only_accepted_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    exec_en |-> $past(loaded_o && cmd_valid_i && (cmd_op_i == CMD_ROT || cmd_op_i == CMD_TRN)));

  p_rot_corner_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    exec_en && !exec_trn |=> cell_q[0] == $past(cell_q[(N-1)*N]));

  p_trn_diag_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    exec_en && exec_trn |=> cell_q[0] == $past(cell_q[0]) &&
                            cell_q[N*N-1] == $past(cell_q[N*N-1]) &&
                            cell_q[1] == $past(cell_q[N]));
endmodule

bind mat_rot_array mat_rot_array_chk #(.N(N), .W(W)) u_chk (.*);

// File: tb/sim_mat_rot_array.sv
module sim_mat_rot_array;
  localparam int N     = 4;
  localparam int W     = 8;
  localparam int DEPTH = 4;
  localparam int NN    = N*N;

  typedef int mat_t [NN];

  logic         clk_i = 1'b0;
  logic         rst_ni = 1'b0;
  logic         in_valid_i = 1'b0;
  logic [W-1:0] in_data_i = '0;
  logic         in_ready_o;
  logic         out_valid_o;
  logic [W-1:0] out_data_o;
  logic         out_ready_i = 1'b0;
  logic         cmd_valid_i = 1'b0;
  logic [1:0]   cmd_op_i = 2'b00;
  logic         busy_o, loaded_o;

  int checks = 0;
  int fails  = 0;

  always #4 clk_i = ~clk_i;

  mat_rot_array #(.N(N), .W(W), .FIFO_DEPTH(DEPTH)) u0 (.*);

  function automatic mat_t rot(mat_t a);
    mat_t r;
    for (int i = 0; i < N; i++)
      for (int j = 0; j < N; j++) r[i*N+j] = a[(N-1-j)*N+i];
    return r;
  endfunction

  function automatic mat_t trn(mat_t a);
    mat_t r;
    for (int i = 0; i < N; i++)
      for (int j = 0; j < N; j++) r[i*N+j] = a[j*N+i];
    return r;
  endfunction

  function automatic mat_t mk(int base, int step);
    mat_t r;
    for (int k = 0; k < NN; k++) r[k] = (base + k*step) & 8'hff;
    return r;
  endfunction

  task automatic chk(bit ok, string req, string what, int act, int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s %s: got %0d expected %0d", req, what, act, exp);
    end
  endtask

  task automatic push_word(int v);
    int t = 0;
    @(negedge clk_i);
    while (!in_ready_o && t < 1000) begin @(negedge clk_i); t++; end
    in_valid_i = 1'b1;
    in_data_i  = W'(v);
    @(negedge clk_i);
    in_valid_i = 1'b0;
  endtask

  task automatic wait_loaded(string req);
    int t = 0;
    while (!loaded_o && t < 1000) begin @(negedge clk_i); t++; end
    chk(loaded_o, req, "loaded_o after load", int'(loaded_o), 1);
  endtask

  task automatic load(mat_t m, string req);
    for (int k = 0; k < NN; k++) push_word(m[k]);
    wait_loaded(req);
  endtask

  task automatic cmd(logic [1:0] op, int len);
    @(negedge clk_i);
    cmd_valid_i = 1'b1;
    cmd_op_i    = op;
    repeat (len) @(negedge clk_i);
    cmd_valid_i = 1'b0;
    cmd_op_i    = 2'b00;
  endtask

  task automatic exec(logic [1:0] op);
    cmd(op, 1);
    chk(busy_o, "R2", "busy_o in execute cycle", int'(busy_o), 1);
    @(negedge clk_i);
    chk(loaded_o, "R2", "loaded_o after execute", int'(loaded_o), 1);
  endtask

  task automatic drain_check(mat_t exp, string req, int stall);
    mat_t got;
    int n = 0;
    int t = 0;
    int bad = -1;
    logic [W-1:0] head;
    cmd(2'b11, 1);
    if (stall > 0) begin
      repeat (stall) @(negedge clk_i);
      chk(out_valid_o, "R7", "out_valid_o during stall", int'(out_valid_o), 1);
      head = out_data_o;
      repeat (3) @(negedge clk_i);
      chk(out_data_o == head && head == W'(exp[0]), "R7", "head word held", int'(out_data_o), exp[0]);
    end
    out_ready_i = 1'b1;
    while (n < NN && t < 2000) begin
      if (out_valid_o) begin got[n] = int'(out_data_o); n++; end
      @(negedge clk_i);
      t++;
    end
    out_ready_i = 1'b0;
    chk(n == NN, "R6", "drained word count", n, NN);
    for (int k = NN-1; k >= 0; k--) if (k < n && got[k] != exp[k]) bad = k;
    if (bad >= 0) chk(1'b0, req, $sformatf("drained word %0d", bad), got[bad], exp[bad]);
    else          chk(1'b1, req, "drained matrix", 0, 0);
    repeat (4) @(negedge clk_i);
    chk(!out_valid_o, "R6", "no extra word after drain", int'(out_valid_o), 0);
  endtask

  task automatic t_reset;
    chk(!out_valid_o, "R8", "out_valid_o in reset", int'(out_valid_o), 0);
    chk(!loaded_o,    "R8", "loaded_o in reset",    int'(loaded_o),    0);
    chk(busy_o,       "R8", "busy_o in reset",      int'(busy_o),      1);
    chk(in_ready_o,   "R8", "in_ready_o in reset",  int'(in_ready_o),  1);
    @(negedge clk_i);
    rst_ni = 1'b1;
    repeat (2) @(negedge clk_i);
    chk(!out_valid_o && !loaded_o && busy_o && in_ready_o, "R8", "state after release", int'(loaded_o), 0);
  endtask

  task automatic t_load_rotate;
    mat_t a = mk(1, 1);
    for (int k = 0; k < NN-1; k++) push_word(a[k]);
    repeat (4) @(negedge clk_i);
    chk(!loaded_o, "R1", "loaded_o before last word", int'(loaded_o), 0);
    push_word(a[NN-1]);
    wait_loaded("R1");
    exec(2'b01);
    drain_check(rot(a), "R2", 0);
  endtask

  task automatic t_transpose;
    mat_t b = mk(200, 3);
    load(b, "R1");
    exec(2'b10);
    drain_check(trn(b), "R3", 0);
  endtask

  task automatic t_chain;
    mat_t c = mk(17, 7);
    load(c, "R1");
    repeat (4) exec(2'b01);
    drain_check(c, "R4", 0);
    load(c, "R1");
    repeat (2) exec(2'b10);
    drain_check(c, "R4", 0);
    load(c, "R1");
    exec(2'b01);
    exec(2'b10);
    drain_check(trn(rot(c)), "R4", 0);
  endtask

  task automatic t_drop;
    mat_t d = mk(90, 5);
    for (int k = 0; k < NN/2; k++) push_word(d[k]);
    cmd(2'b01, 1);
    for (int k = NN/2; k < NN; k++) push_word(d[k]);
    wait_loaded("R5");
    cmd(2'b00, 1);
    chk(loaded_o, "R5", "no-op keeps loaded_o", int'(loaded_o), 1);
    cmd(2'b01, 2);
    @(negedge clk_i);
    drain_check(rot(d), "R5", 0);
  endtask

  task automatic t_stall;
    mat_t e = mk(60, 11);
    load(e, "R1");
    drain_check(e, "R7", 20);
  endtask

  task automatic t_backpressure;
    mat_t f = mk(33, 9);
    mat_t g = mk(140, 13);
    load(f, "R1");
    for (int k = 0; k < DEPTH; k++) push_word(g[k]);
    @(negedge clk_i);
    chk(!in_ready_o, "R9", "in_ready_o with full input FIFO", int'(in_ready_o), 0);
    drain_check(f, "R9", 0);
    for (int k = DEPTH; k < NN; k++) push_word(g[k]);
    wait_loaded("R9");
    drain_check(g, "R9", 0);
  endtask

  initial begin
    repeat (150000) @(posedge clk_i);
    checks++;
    fails++;
    $display("FAIL watchdog expired");
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk_i);
    t_reset;
    t_load_rotate;
    t_transpose;
    t_chain;
    t_drop;
    t_stall;
    t_backpressure;
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end
endmodule